// File: doc/BRIEF.md
# Shift and Signed-Multiply Execution Unit

This block is a 32-bit execution slice that performs logical shifts and a signed multiply for a simple integer pipeline. A 6-bit function code picks the operation. Two of the shift codes take their distance from a 5-bit immediate input. The other two take it from the low five bits of the second register operand. In every case the first operand is the value that gets shifted. The multiply code forms the full 64-bit two's-complement product of both operands and places it in a dedicated high/low register pair, not on the result bus.

All outputs are registered. A result appears on `result` one clock after its inputs are presented. A product appears on `hi` and `lo` one clock after the multiply code is presented. The pair holds its value through every other operation, so later instructions can read it out.

Top module: `alu_shift_mul`

## Requirements
- R1: Function code 6'b000000 sets `result`, on the next rising clock edge, to `op_a` shifted left by `shamt`.
- R2: Function code 6'b000010 sets `result`, on the next rising clock edge, to `op_a` shifted right by `shamt`.
- R3: Function code 6'b000100 sets `result` to `op_a` shifted left by `op_b[4:0]`. Bits 31..5 of `op_b` have no effect.
- R4: Function code 6'b000110 sets `result` to `op_a` shifted right by `op_b[4:0]`. Bits 31..5 of `op_b` have no effect.
- R5: Every shift fills vacated bit positions with zero and drops bits moved past either end. A shift distance of 0 returns `op_a` unchanged.
- R6: Function code 6'b011000 loads `{hi, lo}` on the next rising edge with the 64-bit signed product of `op_a` and `op_b`. `hi` holds bits 63..32 and `lo` holds bits 31..0.
- R7: For function code 6'b011000, `result` is 0 on the following cycle.
- R8: Any function code other than 6'b011000 leaves `hi` and `lo` unchanged. Any code outside the five listed drives `result` to 0.
- R9: While `rst` is high at a rising edge, `result`, `hi` and `lo` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | First operand; the value that is shifted; multiplicand |
| op_b | input | 32 | Second operand; its low 5 bits give the variable shift distance; multiplier |
| shamt | input | 5 | Immediate shift distance |
| func | input | 6 | Function code |
| result | output | 32 | Registered shift result, 0 for multiply and unlisted codes |
| hi | output | 32 | Registered upper half of the last product |
| lo | output | 32 | Registered lower half of the last product |

## Verification
The bench applies distances 0, 1 and 31, and walking patterns whose set bits fall off either end. A shifter that rotated, filled with ones or miscounted a stage would leave stray ones or shift by the wrong distance. Variable shifts are driven with junk in the upper bits of `op_b`, so a design that used more than five amount bits returns zero or a wrong value. The multiply is run with mixed signs and with the most negative operand. An unsigned or truncated multiplier would show a wrong `hi`. After a product is loaded, shifts and unlisted codes are applied to confirm that `hi` and `lo` hold and that `result` is 0 where R7 and R8 require it.

// File: rtl/alu_sm_pkg.sv
package alu_sm_pkg;
  localparam int unsigned FUNC_W = 6;

  typedef enum logic [FUNC_W-1:0] {
    FN_SLL_IMM = 6'b000000,
    FN_SRL_IMM = 6'b000010,
    FN_SLL_VAR = 6'b000100,
    FN_SRL_VAR = 6'b000110,
    FN_MUL     = 6'b011000
  } func_e;
endpackage

// File: rtl/alu_sm_decode.sv
module alu_sm_decode
  import alu_sm_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output logic              is_shift,
  output logic              shift_right,
  output logic              amt_from_reg,
  output logic              is_mul
);
  always_comb begin
    is_shift     = 1'b0;
    shift_right  = 1'b0;
    amt_from_reg = 1'b0;
    is_mul       = 1'b0;
    case (func)
      FN_SLL_IMM: is_shift = 1'b1;
      FN_SRL_IMM: begin is_shift = 1'b1; shift_right = 1'b1; end
      FN_SLL_VAR: begin is_shift = 1'b1; amt_from_reg = 1'b1; end
      FN_SRL_VAR: begin is_shift = 1'b1; amt_from_reg = 1'b1; shift_right = 1'b1; end
      FN_MUL:     is_mul = 1'b1;
      default:    ;
    endcase
  end
endmodule

// File: rtl/alu_sm_shifter.sv
module alu_sm_shifter #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          to_right,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:AW];

  assign stage[0] = din;

  for (genvar i = 0; i < AW; i++) begin : g_stage
    localparam int unsigned DIST = 1 << i;
    logic [W-1:0] moved;
    assign moved        = to_right ? (stage[i] >> DIST) : (stage[i] << DIST);
    assign stage[i + 1] = amt[i] ? moved : stage[i];
  end

  assign dout = stage[AW];
endmodule

// File: rtl/alu_sm_mult.sv
module alu_sm_mult #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  logic signed [2*W-1:0] a_ext;
  logic signed [2*W-1:0] b_ext;

  assign a_ext = {{W{a[W-1]}}, a};
  assign b_ext = {{W{b[W-1]}}, b};
  assign prod  = a_ext * b_ext;
endmodule

// File: rtl/alu_shift_mul.sv
module alu_shift_mul
  import alu_sm_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [AW-1:0]     shamt,
  input  logic [FUNC_W-1:0] func,
  output logic [W-1:0]      result,
  output logic [W-1:0]      hi,
  output logic [W-1:0]      lo
);
  logic           is_shift, shift_right, amt_from_reg, is_mul;
  logic [AW-1:0]  amt_sel;
  logic [W-1:0]   sh_out;
  logic [2*W-1:0] prod;

  alu_sm_decode u_dec (
    .func         (func),
    .is_shift     (is_shift),
    .shift_right  (shift_right),
    .amt_from_reg (amt_from_reg),
    .is_mul       (is_mul)
  );

  assign amt_sel = amt_from_reg ? op_b[AW-1:0] : shamt;

  alu_sm_shifter #(.W(W), .AW(AW)) u_shf (
    .din      (op_a),
    .amt      (amt_sel),
    .to_right (shift_right),
    .dout     (sh_out)
  );

  alu_sm_mult #(.W(W)) u_mul (
    .a    (op_a),
    .b    (op_b),
    .prod (prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      hi     <= '0;
      lo     <= '0;
    end else begin
      result <= is_shift ? sh_out : '0;
      if (is_mul) begin
        hi <= prod[2*W-1:W];
        lo <= prod[W-1:0];
      end
    end
  end
endmodule

// File: rtl/alu_shift_mul_chk.sv
module alu_shift_mul_chk
  import alu_sm_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input logic              clk,
  input logic              rst,
  input logic [W-1:0]      op_a,
  input logic [W-1:0]      op_b,
  input logic [AW-1:0]     shamt,
  input logic [FUNC_W-1:0] func,
  input logic [W-1:0]      result,
  input logic [W-1:0]      hi,
  input logic [W-1:0]      lo
);
  assert_zero_imm_passthru_R5: assert property (@(posedge clk) disable iff (rst)
    ((func == FN_SLL_IMM || func == FN_SRL_IMM) && shamt == '0) |=> (result == $past(op_a)));

  assert_zero_var_passthru_R3: assert property (@(posedge clk) disable iff (rst)
    ((func == FN_SLL_VAR || func == FN_SRL_VAR) && op_b[AW-1:0] == '0) |=> (result == $past(op_a)));

  assert_right_msb_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (func == FN_SRL_IMM && shamt != '0) |=> (result[W-1] == 1'b0));

  assert_left_lsb_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (func == FN_SLL_IMM && shamt != '0) |=> (result[0] == 1'b0));

  assert_mul_result_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (func == FN_MUL) |=> (result == '0));

  assert_mul_by_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (func == FN_MUL && op_a == '0) |=> (hi == '0 && lo == '0));

  assert_hilo_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (func != FN_MUL) |=> ($stable(hi) && $stable(lo)));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (result == '0 && hi == '0 && lo == '0));
endmodule

bind alu_shift_mul alu_shift_mul_chk #(.W(W), .AW(AW)) u_chk (.*);

// File: tb/alu_shift_mul_tb.sv
module alu_shift_mul_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] op_a, op_b;
  logic [4:0]  shamt;
  logic [5:0]  func;
  logic [31:0] result, hi, lo;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  alu_shift_mul u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .shamt(shamt),
    .func(func), .result(result), .hi(hi), .lo(lo)
  );

  typedef struct packed {
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  sa;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{6'b000000, 32'h00000009, 32'h00000000, 5'd4,  32'h00000090}, // R1
    '{6'b000000, 32'hFFFFFFFF, 32'h00000000, 5'd7,  32'hFFFFFF80}, // R1 R5
    '{6'b000010, 32'h10010000, 32'h00000000, 5'd8,  32'h00100100}, // R2
    '{6'b000010, 32'h80000000, 32'h00000000, 5'd31, 32'h00000001}, // R2 R5
    '{6'b000100, 32'h00000001, 32'hFFFFFFE3, 5'd9,  32'h00000008}, // R3
    '{6'b000110, 32'hF0000000, 32'h00000024, 5'd1,  32'h0F000000}, // R4
    '{6'b000000, 32'hA5A5A5A5, 32'h00000000, 5'd0,  32'hA5A5A5A5}, // R5
    '{6'b000100, 32'h12345678, 32'hFFFFFFE0, 5'd3,  32'h12345678}, // R5
    '{6'b000000, 32'h80000001, 32'h00000000, 5'd1,  32'h00000002}, // R5
    '{6'b011000, 32'h00000005, 32'h00000007, 5'd2,  32'h00000000}, // R7
    '{6'b100001, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3,  32'h00000000}  // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] s);
    @(negedge clk);
    func = f; op_a = a; op_b = b; shamt = s;
    @(negedge clk);
  endtask

  task automatic mul_case(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] p;
    p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    apply(6'b011000, a, b, 5'd0);
    check("R6 hi", hi, p[63:32]);
    check("R6 lo", lo, p[31:0]);
    check("R7 result", result, 32'h0);
  endtask

  initial begin
    rst = 1'b1; func = 6'b111111; op_a = '0; op_b = '0; shamt = '0;
    repeat (3) @(negedge clk);
    check("R9 reset result", result, 32'h0);
    check("R9 reset hi", hi, 32'h0);
    check("R9 reset lo", lo, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].fn, VECS[i].a, VECS[i].b, VECS[i].sa);
      check($sformatf("R1-table vec%0d", i), result, VECS[i].exp);
    end

    mul_case(32'hFFFFFFFC, 32'hFFFFFFFD);
    mul_case(32'h7FFFFFFF, 32'h7FFFFFFF);
    mul_case(32'hFFFFFFFF, 32'h00000002);
    mul_case(32'h80000000, 32'h80000000);
    mul_case(32'h80000000, 32'h00000001);
    mul_case(32'h12345678, 32'hFEDCBA98);

    // R8: hi/lo hold (last product 0x12345678 * 0xFEDCBA98) across other codes
    begin
      logic signed [63:0] keep;
      keep = $signed({32'h0, 32'h12345678}) * $signed({32'hFFFFFFFF, 32'hFEDCBA98});
      apply(6'b000010, 32'hFFFF0000, 32'h0, 5'd16);
      check("R8 hi after shift", hi, keep[63:32]);
      check("R8 lo after shift", lo, keep[31:0]);
      check("R2 shift after mul", result, 32'h0000FFFF);
      apply(6'b011001, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd1);
      check("R8 unlisted result", result, 32'h0);
      check("R8 hi after unlisted", hi, keep[63:32]);
      check("R8 lo after unlisted", lo, keep[31:0]);
    end

    apply(6'b000110, 32'hFFFFFFFF, 32'h0000003F, 5'd0);
    check("R4 max var right", result, 32'h00000001);
    apply(6'b000100, 32'hFFFFFFFF, 32'hAAAAAA9F, 5'd0);
    check("R3 max var left", result, 32'h80000000);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset hi", hi, 32'h0);
    check("R9 mid reset lo", lo, 32'h0);
    check("R9 mid reset result", result, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule